// File: doc/BRIEF.md
# Shared-Pin Parallel Port with Two Serial-Link Overlays

This block is an eight-bit bidirectional general-purpose I/O port. Software reaches it through a small register bus that holds a data latch and a direction register. Two SPI modules, called unit 0 and unit 1, share the port's pins. For each pin the block decides whether the port registers or an SPI unit drives the pad, and what the pad's direction is. It then hands the synchronized pin states back to the SPI units and to register reads.

Each SPI unit supplies an enable, a master-mode flag and a per-pin output value. An enabled unit takes over its data and clock pins. Their direction is fixed by master or slave mode, and the direction register is ignored on those pins. The unit's slave-select pin returns to the port whenever that unit runs as master. A register read always follows the direction bits, even on pins an SPI unit owns. The SPI shift logic, clock generation and pad electrical behaviour sit outside this block.

Top module: `gpio_spi_port`

## Requirements
- R1: A bus write to offset 0x3 loads the data latch on that clock edge. A read of offset 0x3 returns the latch value on every bit whose direction bit is 1.
- R2: The direction register sits at offset 0x7 and reads back there. Reset clears it to 0x00, so every pin starts as an input. A direction bit of 1 means output. While no SPI unit owns a pin, `pad_oe` equals the direction bit and `pad_out` equals the latch bit.
- R3: Reset does not change the data latch. A bus write made while reset is asserted changes neither register.
- R4: The pins are mapped as follows. Unit 0 owns bit 0 (MISO), bit 1 (MOSI), bit 2 (SS) and bit 3 (SCK). Unit 1 owns bit 4 (SCK), bit 5 (SS), bit 6 (MOSI) and bit 7 (MISO).
- R5: While a unit's enable is 0, all four of its pins behave as plain port pins.
- R6: A slave-select pin is a plain port pin when its unit is disabled or in master mode. When its unit is enabled in slave mode, the pin is owned by the unit and is always an input (`pad_oe` is 0).
- R7: On an owned pin the direction register has no effect. In master mode, MOSI and SCK are outputs and MISO is an input. In slave mode, MISO is an output and MOSI and SCK are inputs. An owned output pin drives the matching `spi_out` bit.
- R8: A read of offset 0x3 returns the synchronized pin state on every bit whose direction bit is 0. This holds on owned pins as well.
- R9: A change on `pad_in` reaches `spi_in` and port reads two clock edges later. The synchronizer stages reset to 0.
- R10: A read of any offset other than 0x3 and 0x7 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from `bus_addr`) |
| spi_en | input | 2 | Enable of SPI unit 1 (bit 1) and unit 0 (bit 0) |
| spi_master | input | 2 | Master-mode flag per unit |
| spi_out | input | 8 | Per-pin output value from the SPI units |
| spi_in | output | 8 | Synchronized pin states sent to the SPI units |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable, 1 means drive |

## Verification
A direction-register write and an SPI takeover of the same pin can be in force at once. On such a pin the mode must win for `pad_oe`, while the same direction bit still selects what a port read returns. The vector table provokes this overlap. It programs direction patterns that disagree with each unit's mode-defined directions, including one vector with a unit in master mode beside the other in slave mode. It then checks `pad_oe`, `pad_out` and the read value together against values worked out per pin from the mapping.

// File: rtl/gpio_spi_pkg.sv
// Package: shared widths, register offsets and the pin-role map for the
// shared-pin port. Assumes two SPI units with four pins each, eight pins total.
package gpio_spi_pkg;

    localparam int PORT_W  = 8;
    localparam int UNITS   = 2;
    localparam int ADDR_W  = 3;
    localparam logic [ADDR_W-1:0] OFS_DATA = 3'h3;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 3'h7;

    typedef enum logic [1:0] {
        ROLE_MISO = 2'd0,
        ROLE_MOSI = 2'd1,
        ROLE_SS   = 2'd2,
        ROLE_SCK  = 2'd3
    } pin_role_e;

    // Unit that may claim a given pin: lower half unit 0, upper half unit 1.
    function automatic int unit_of(input int idx);
        return (idx < PORT_W / UNITS) ? 0 : 1;
    endfunction

    // Role of a pin. Unit 1's pins mirror unit 0's pins in reverse order.
    function automatic pin_role_e role_of(input int idx);
        int k;
        k = (idx < PORT_W / UNITS) ? idx : (PORT_W - 1 - idx);
        case (k)
            0:       return ROLE_MISO;
            1:       return ROLE_MOSI;
            2:       return ROLE_SS;
            default: return ROLE_SCK;
        endcase
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
// Module: data latch and direction register behind the register bus.
// Assumes a single-cycle write strobe. The latch has no reset on purpose:
// its contents survive reset. During reset all writes are blocked.
module gpio_port_regs
    import gpio_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q
);

    // Data latch: loaded by writes to the data offset, untouched by reset.
    always_ff @(posedge clk) begin
        if (rst_n && wr && addr == OFS_DATA)
            latch_q <= wdata;
    end

    // Direction register: cleared by reset, loaded by writes to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr && addr == OFS_DIR)
            dir_q <= wdata;
    end

endmodule

// File: rtl/gpio_pin_sync.sv
// Module: two-stage synchronizer for the raw pad inputs.
// Assumes that the pad levels are asynchronous to clk. Both stages reset to 0.
module gpio_pin_sync
    #(parameter int W = 8)
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Two flops in series; the second stage is the synchronized output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/gpio_pin_mux.sv
// Module: per-pin ownership and direction selection.
// Assumes the pin-role map from the package. Purely combinational.
module gpio_pin_mux
    import gpio_spi_pkg::*;
(
    input  logic [UNITS-1:0]  spi_en,
    input  logic [UNITS-1:0]  spi_master,
    input  logic [PORT_W-1:0] spi_out,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        localparam int        UNIT = unit_of(i);
        localparam pin_role_e ROLE = role_of(i);

        logic owned;
        logic spi_drive;

        // Decide whether this pin's unit claims it and which direction the mode sets.
        always_comb begin
            owned = spi_en[UNIT] && !(ROLE == ROLE_SS && spi_master[UNIT]);
            case (ROLE)
                ROLE_MISO: spi_drive = !spi_master[UNIT];
                ROLE_SS:   spi_drive = 1'b0;
                default:   spi_drive = spi_master[UNIT];
            endcase
        end

        // Select the pad value and enable from either the SPI or the port registers.
        always_comb begin
            pad_oe[i]  = owned ? spi_drive  : dir_q[i];
            pad_out[i] = owned ? spi_out[i] : latch_q[i];
        end
    end

endmodule

// File: rtl/gpio_spi_port.sv
// Module: top of the eight-pin port that shares its pins with two SPI units.
// Assumes synchronous active-low reset and a combinational read path.
module gpio_spi_port
    import gpio_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [UNITS-1:0]  spi_en,
    input  logic [UNITS-1:0]  spi_master,
    input  logic [PORT_W-1:0] spi_out,
    output logic [PORT_W-1:0] spi_in,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe
);

    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] pin_sync;

    gpio_port_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_pin_sync #(.W(PORT_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    gpio_pin_mux u_mux (
        .spi_en     (spi_en),
        .spi_master (spi_master),
        .spi_out    (spi_out),
        .latch_q    (latch_q),
        .dir_q      (dir_q),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    // Hand the synchronized pin states to the SPI units.
    assign spi_in = pin_sync;

    // Register read: the direction bit picks the latch or the pin on each bit.
    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = (latch_q & dir_q) | (pin_sync & ~dir_q);
            OFS_DIR:  bus_rdata = dir_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_spi_port_chk.sv
// Checker: temporal properties of the shared-pin port, bound to the top.
// Assumes the package offsets and pin map.
module gpio_spi_port_chk
    import gpio_spi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [UNITS-1:0]  spi_en,
    input logic [UNITS-1:0]  spi_master,
    input logic [PORT_W-1:0] spi_out,
    input logic [PORT_W-1:0] spi_in,
    input logic [PORT_W-1:0] pad_in,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_oe
);

    logic [1:0] since_rst;

    // Count edges since reset was released, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    // R2/R5: with both units off, a direction write shows directly on pad_oe.
    a_r5_dir_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR && spi_en == '0 && $stable(spi_en)) |=>
        (spi_en != '0 || pad_oe == $past(bus_wdata)));

    // R6: a slave-select pin owned in slave mode is never driven.
    a_r6_ss_input: assert property (@(posedge clk) disable iff (!rst_n)
        ((spi_en[0] && !spi_master[0]) |-> !pad_oe[2]) and
        ((spi_en[1] && !spi_master[1]) |-> !pad_oe[5]));

    // R7: in master mode, MOSI and SCK drive and MISO listens.
    a_r7_master_dirs: assert property (@(posedge clk) disable iff (!rst_n)
        ((spi_en[0] && spi_master[0]) |-> (pad_oe[1] && pad_oe[3] && !pad_oe[0])) and
        ((spi_en[1] && spi_master[1]) |-> (pad_oe[6] && pad_oe[4] && !pad_oe[7])));

    // R7: in slave mode, MISO drives the SPI value and MOSI and SCK listen.
    a_r7_slave_dirs: assert property (@(posedge clk) disable iff (!rst_n)
        ((spi_en[0] && !spi_master[0]) |->
            (pad_oe[0] && !pad_oe[1] && !pad_oe[3] && pad_out[0] == spi_out[0])) and
        ((spi_en[1] && !spi_master[1]) |->
            (pad_oe[7] && !pad_oe[6] && !pad_oe[4] && pad_out[7] == spi_out[7])));

    // R9: the synchronized pins lag the pads by exactly two edges.
    a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (spi_in == $past(pad_in, 2)));

endmodule

bind gpio_spi_port gpio_spi_port_chk u_chk (.*);

// File: tb/sim_gpio_spi_port.sv
// Bench for the shared-pin port: a table of vectors walked by one loop, then
// directed tests for reset, synchronizer latency and address decode.
module sim_gpio_spi_port;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_wr;
    logic [2:0]   bus_addr;
    logic [W-1:0] bus_wdata;
    logic [W-1:0] bus_rdata;
    logic [1:0]   spi_en;
    logic [1:0]   spi_master;
    logic [W-1:0] spi_out;
    logic [W-1:0] spi_in;
    logic [W-1:0] pad_in;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gpio_spi_port u0 (.*);

    // Vector fields: en, master, direction, expected pad_oe, expected pad_out.
    // The latch holds 8'hA5 and spi_out is 8'h3C in every vector.
    typedef struct packed {
        logic [1:0]   en;
        logic [1:0]   mst;
        logic [W-1:0] dir;
        logic [W-1:0] oe;
        logic [W-1:0] out;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 2'b00, 8'hFF, 8'hFF, 8'hA5},
        '{2'b00, 2'b11, 8'h0F, 8'h0F, 8'hA5},
        '{2'b01, 2'b01, 8'h00, 8'h0A, 8'hAC},
        '{2'b01, 2'b00, 8'hFF, 8'hF1, 8'hAC},
        '{2'b10, 2'b10, 8'h00, 8'h50, 8'h35},
        '{2'b10, 2'b00, 8'hFF, 8'h8F, 8'h35},
        '{2'b11, 2'b11, 8'h24, 8'h7E, 8'h3C},
        '{2'b11, 2'b00, 8'hFF, 8'h81, 8'h3C},
        '{2'b11, 2'b01, 8'h00, 8'h8A, 8'h3C}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 3'h0; bus_wdata = '0;
        spi_en = '0; spi_master = '0; spi_out = 8'h3C; pad_in = 8'h5A;
        repeat (3) @(negedge clk);
        // R2/R9: reset state, all inputs and synchronizer cleared
        check("R2 reset pad_oe", pad_oe, 8'h00);
        bus_addr = 3'h7; #1;
        check("R2 reset dir", bus_rdata, 8'h00);
        check("R9 sync reset", spi_in, 8'h00);
        rst_n = 1'b1;
        bus_write(3'h3, 8'hA5);                     // R1
        repeat (2) @(negedge clk);

        // Table walk: R2 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            bus_write(3'h7, VECS[v].dir);
            spi_en = VECS[v].en; spi_master = VECS[v].mst;
            bus_addr = 3'h3; #1;
            check("R7 R6 R4 pad_oe", pad_oe, VECS[v].oe);
            check("R7 R5 pad_out", pad_out, VECS[v].out);
            check("R8 R1 read", bus_rdata,
                  (8'hA5 & VECS[v].dir) | (8'h5A & ~VECS[v].dir));
        end

        // R3: latch survives reset; a write during reset is dropped
        spi_en = '0; spi_master = '0;
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b1; bus_addr = 3'h3; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0; rst_n = 1'b1;
        bus_addr = 3'h7; #1;
        check("R3 dir cleared", bus_rdata, 8'h00);
        bus_write(3'h7, 8'hFF);
        bus_addr = 3'h3; #1;
        check("R3 latch kept", bus_rdata, 8'hA5);
        check("R3 R2 pad_out", pad_out, 8'hA5);

        // R9: two-edge latency of the pin path
        bus_write(3'h7, 8'h00);
        repeat (2) @(negedge clk);
        pad_in = 8'hC3;
        @(negedge clk);
        bus_addr = 3'h3; #1;
        check("R9 after one edge", spi_in, 8'h5A);
        @(negedge clk); #1;
        check("R9 after two edges", spi_in, 8'hC3);
        check("R9 R8 read", bus_rdata, 8'hC3);

        // R10: unused offsets read as zero
        bus_addr = 3'h0; #1;
        check("R10 offset 0", bus_rdata, 8'h00);
        bus_addr = 3'h5; #1;
        check("R10 offset 5", bus_rdata, 8'h00);

        summary();
    end

endmodule